// File: doc/BRIEF.md
# Multi-Register Byte-String Transfer Sequencer

This block moves a run of bytes between a byte-addressed memory port and a file of 32-bit registers that sits outside it. A one-cycle start pulse supplies a base address, a byte count, the first register number and the direction. For a load, data goes from memory into registers. For a store, data goes from registers into memory. While four or more bytes are left, the block moves whole words. Any final one to three bytes move one at a time: they are packed into, or taken from, the top of the current register, most significant byte first. The register number steps up after every word and wraps from the last register back to register 0.

An indexed variant first works out how many registers the transfer will touch and compares that span against two protected operand register numbers, A and B. Operand A is exempt when it is zero. If either protected register falls in the span, the block reports an error and makes no transfer.

The controller is a five-state machine. ST_IDLE waits for start. ST_SCREEN runs the overlap test for the indexed variant. ST_WORD issues word requests. ST_TAIL issues byte requests. ST_DONE gives a one-cycle completion pulse. The transitions are:
- ST_IDLE to ST_SCREEN on an indexed start, or straight to ST_WORD, ST_TAIL or ST_DONE on a plain start, chosen by the count.
- ST_SCREEN to ST_DONE on a hit. Otherwise ST_SCREEN takes the same count-based route as a plain start.
- ST_WORD loops to itself after each accepted word, or moves to ST_TAIL or ST_DONE by the count that is left.
- ST_TAIL loops to itself until its last byte is accepted, then moves to ST_DONE.
- ST_DONE always returns to ST_IDLE.

The register count must be a power of two, so that the register number wraps naturally.

Top module: `lss_string_seq`

## Requirements
- R1: A start pulse is accepted only when busy_o is low. busy_o stays high from the cycle after an accepted start through the done cycle. A start pulse that arrives while busy_o is high changes nothing: it adds no memory request and no register write.
- R2: While four or more bytes remain, each request is a word request (mem_word_o=1). Successive word addresses differ by 4. The register number rises by one per word, and register 31 is followed by register 0. A loaded word is the four memory bytes at addr..addr+3, with the byte at addr placed in bits 31:24.
- R3: On a load, a remaining tail of 1 to 3 bytes is fetched by byte requests (mem_word_o=0) at consecutive addresses. The byte is returned in mem_rdata_i[7:0]. The tail bytes are placed in bits 31:24, then 23:16, then 15:8 of the current register, and every bit not filled is zero.
- R4: On a store, words are written from the register value unchanged, with bits 31:24 going to the lowest address. Tail bytes are written one per request, in mem_wdata_o[7:0], taken from bits 31:24, then 23:16, then 15:8 of the current register.
- R5: All address increments wrap modulo 2^32.
- R6: A byte count of zero produces no memory request and no register write, and it completes with err_o low. This holds for both the plain and the indexed variants.
- R7: For the indexed variant (indexed_i=1), the span is ceil(count/4) registers starting at the first register, wrapping past 31. If the span contains op_b_i, or contains a nonzero op_a_i, the block completes with err_o high and makes no memory request and no register write.
- R8: For the indexed variant, op_a_i equal to 0 never causes an error, even when register 0 lies in the span.
- R9: done_o is a single-cycle pulse in the cycle after the last accepted request, or after the screening step. err_o is high only together with done_o.
- R10: The block has at most one request outstanding. A request that is not accepted keeps its address, write enable and size unchanged until mem_ready_i is high.
- R11: The register file is written only on a load, and only in a cycle where a memory request is accepted. A store never writes the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start request |
| store_i | input | 1 | 1 = registers to memory, 0 = memory to registers |
| indexed_i | input | 1 | 1 = run the operand-overlap screen first |
| base_addr_i | input | AW | First byte address |
| byte_cnt_i | input | CW | Number of bytes to move |
| first_reg_i | input | RW | First register number |
| op_a_i | input | RW | Protected operand A (exempt when 0) |
| op_b_i | input | RW | Protected operand B |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Overlap error, valid with done_o |
| mem_req_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_addr_o | output | AW | Request byte address |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_word_o | output | 1 | 1 = 32-bit word, 0 = single byte |
| mem_wdata_o | output | DW | Write data (a byte sits in bits 7:0) |
| mem_rdata_i | input | DW | Read data, valid with mem_ready_i (a byte sits in bits 7:0) |
| rf_addr_o | output | RW | Register file address |
| rf_we_o | output | 1 | Register file write enable |
| rf_wdata_o | output | DW | Register file write data |
| rf_rdata_i | input | DW | Asynchronous read data for rf_addr_o |

## Verification
The hardest case to reach from the ports is a register span that wraps past register 31 and lands on a protected operand near register 0. The same applies to an address stream that crosses 2^32 partway through a word.

The stimulus table puts the first register at 30 or 31 with counts that carry the span across the wrap. It also sets operand B to 0 with operand A at 0, so that the A exemption and the B check meet on the same register. A base address a few bytes below 2^32 makes a word straddle the wrap. A stalling ready pattern on alternate vectors holds requests so that their stability can be watched.

// File: rtl/lss_pkg.sv
package lss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCREEN,
        ST_WORD,
        ST_TAIL,
        ST_DONE
    } lss_state_e;

endpackage

// File: rtl/lss_span_check.sv
module lss_span_check #(
    parameter int RN = 32,
    parameter int CW = 7,
    localparam int RW = $clog2(RN)
) (
    input  logic [RW-1:0] first_i,
    input  logic [RW-1:0] ra_i,
    input  logic [RW-1:0] rb_i,
    input  logic [CW-1:0] cnt_i,
    output logic          hit_o
);

    logic [CW:0]   cnt_plus;
    logic [CW:0]   span_n;
    logic [RW-1:0] dist_a;
    logic [RW-1:0] dist_b;
    logic          hit_a;
    logic          hit_b;

    // registers used = ceil(count / 4), one extra bit against overflow
    assign cnt_plus = {1'b0, cnt_i} + (CW+1)'(3);
    assign span_n   = cnt_plus >> 2;

    // distance from the first register, modulo the register count
    assign dist_a = ra_i - first_i;
    assign dist_b = rb_i - first_i;

    assign hit_a = (ra_i != '0) && ((CW+1)'(dist_a) < span_n);
    assign hit_b = (CW+1)'(dist_b) < span_n;
    assign hit_o = hit_a || hit_b;

    // an empty transfer never overlaps anything
    always_comb begin
        if (cnt_i == '0) begin
            p_empty_span_r6: assert (!hit_o);
        end
    end

endmodule

// File: rtl/lss_lane.sv
module lss_lane #(
    parameter int DW = 32,
    localparam int NB = DW / 8,
    localparam int LW = $clog2(NB)
) (
    input  logic [LW-1:0] lane_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] word_i,
    input  logic [7:0]    byte_i,
    output logic [DW-1:0] packed_o,
    output logic [7:0]    byte_o
);

    logic [7:0] pick [NB];

    // lane 0 is the most significant byte of the register
    for (genvar g = 0; g < NB; g++) begin : g_lane
        localparam int HI = DW - 1 - 8 * g;
        assign packed_o[HI -: 8] = (lane_i == LW'(g)) ? byte_i : acc_i[HI -: 8];
        assign pick[g]           = (lane_i == LW'(g)) ? word_i[HI -: 8] : 8'h00;
    end

    always_comb begin
        byte_o = 8'h00;
        for (int k = 0; k < NB; k++) begin
            byte_o = byte_o | pick[k];
        end
    end

endmodule

// File: rtl/lss_engine.sv
module lss_engine
    import lss_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int RN = 32,
    parameter int CW = 7,
    localparam int RW = $clog2(RN),
    localparam int NB = DW / 8,
    localparam int LW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          store_i,
    input  logic          indexed_i,
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [RW-1:0] first_i,
    input  logic [RW-1:0] ra_i,
    input  logic [RW-1:0] rb_i,
    input  logic          span_hit_i,
    output logic [RW-1:0] chk_first_o,
    output logic [CW-1:0] chk_cnt_o,
    output logic [RW-1:0] chk_ra_o,
    output logic [RW-1:0] chk_rb_o,
    output logic [LW-1:0] lane_o,
    output logic [DW-1:0] acc_o,
    input  logic [DW-1:0] packed_i,
    input  logic [7:0]    tbyte_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic          mem_req_o,
    input  logic          mem_ready_i,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_we_o,
    output logic          mem_word_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic [RW-1:0] rf_addr_o,
    output logic          rf_we_o,
    output logic [DW-1:0] rf_wdata_o,
    input  logic [DW-1:0] rf_rdata_i
);

    lss_state_e    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic [RW-1:0] reg_q;
    logic [LW-1:0] lane_q;
    logic [DW-1:0] acc_q;
    logic          store_q;
    logic          err_q;
    logic [RW-1:0] ra_q;
    logic [RW-1:0] rb_q;
    logic          hs;

    function automatic lss_state_e route(input logic [CW-1:0] c);
        if (c == '0) begin
            return ST_DONE;
        end else if (c >= CW'(NB)) begin
            return ST_WORD;
        end else begin
            return ST_TAIL;
        end
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            cnt_q   <= '0;
            reg_q   <= '0;
            lane_q  <= '0;
            acc_q   <= '0;
            store_q <= 1'b0;
            err_q   <= 1'b0;
            ra_q    <= '0;
            rb_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        addr_q  <= base_i;
                        cnt_q   <= cnt_i;
                        reg_q   <= first_i;
                        lane_q  <= '0;
                        acc_q   <= '0;
                        store_q <= store_i;
                        err_q   <= 1'b0;
                        ra_q    <= ra_i;
                        rb_q    <= rb_i;
                    end
                end
                ST_SCREEN: begin
                    err_q <= span_hit_i;
                end
                ST_WORD: begin
                    if (hs) begin
                        addr_q <= addr_q + AW'(NB);
                        cnt_q  <= cnt_q - CW'(NB);
                        reg_q  <= reg_q + RW'(1);
                    end
                end
                ST_TAIL: begin
                    if (hs) begin
                        addr_q <= addr_q + AW'(1);
                        cnt_q  <= cnt_q - CW'(1);
                        lane_q <= lane_q + LW'(1);
                        acc_q  <= packed_i;
                    end
                end
                ST_DONE: begin
                    err_q <= err_q;
                end
                default: begin
                    err_q <= 1'b0;
                end
            endcase
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = indexed_i ? ST_SCREEN : route(cnt_i);
                end
            end
            ST_SCREEN: state_d = span_hit_i ? ST_DONE : route(cnt_q);
            ST_WORD: begin
                if (hs) begin
                    state_d = route(cnt_q - CW'(NB));
                end
            end
            ST_TAIL: begin
                if (hs && (cnt_q == CW'(1))) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req_o   = (state_q == ST_WORD) || (state_q == ST_TAIL);
        mem_word_o  = (state_q == ST_WORD);
        mem_addr_o  = addr_q;
        mem_we_o    = store_q;
        mem_wdata_o = mem_word_o ? rf_rdata_i : {{(DW-8){1'b0}}, tbyte_i};
        hs          = mem_req_o && mem_ready_i;
        rf_addr_o   = reg_q;
        rf_we_o     = hs && !store_q;
        rf_wdata_o  = mem_word_o ? mem_rdata_i : packed_i;
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_DONE);
        err_o       = (state_q == ST_DONE) && err_q;
        chk_first_o = reg_q;
        chk_cnt_o   = cnt_q;
        chk_ra_o    = ra_q;
        chk_rb_o    = rb_q;
        lane_o      = lane_q;
        acc_o       = acc_q;
    end

    p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_word_o)));

    p_word_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ready_i && mem_word_o) |=>
            (!mem_req_o || (mem_addr_o == $past(mem_addr_o) + AW'(NB))));

    p_byte_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ready_i && !mem_word_o) |=>
            (!mem_req_o || (mem_addr_o == $past(mem_addr_o) + AW'(1))));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_err_no_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(state_q == ST_SCREEN));

endmodule

// File: rtl/lss_string_seq.sv
module lss_string_seq #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int RN = 32,
    parameter int CW = 7,
    localparam int RW = $clog2(RN),
    localparam int LW = $clog2(DW / 8)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          store_i,
    input  logic          indexed_i,
    input  logic [AW-1:0] base_addr_i,
    input  logic [CW-1:0] byte_cnt_i,
    input  logic [RW-1:0] first_reg_i,
    input  logic [RW-1:0] op_a_i,
    input  logic [RW-1:0] op_b_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic          mem_req_o,
    input  logic          mem_ready_i,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_we_o,
    output logic          mem_word_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic [RW-1:0] rf_addr_o,
    output logic          rf_we_o,
    output logic [DW-1:0] rf_wdata_o,
    input  logic [DW-1:0] rf_rdata_i
);

    logic [RW-1:0] chk_first;
    logic [CW-1:0] chk_cnt;
    logic [RW-1:0] chk_ra;
    logic [RW-1:0] chk_rb;
    logic          span_hit;
    logic [LW-1:0] lane;
    logic [DW-1:0] acc;
    logic [DW-1:0] packed_w;
    logic [7:0]    tbyte;

    lss_engine #(.AW(AW), .DW(DW), .RN(RN), .CW(CW)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .store_i     (store_i),
        .indexed_i   (indexed_i),
        .base_i      (base_addr_i),
        .cnt_i       (byte_cnt_i),
        .first_i     (first_reg_i),
        .ra_i        (op_a_i),
        .rb_i        (op_b_i),
        .span_hit_i  (span_hit),
        .chk_first_o (chk_first),
        .chk_cnt_o   (chk_cnt),
        .chk_ra_o    (chk_ra),
        .chk_rb_o    (chk_rb),
        .lane_o      (lane),
        .acc_o       (acc),
        .packed_i    (packed_w),
        .tbyte_i     (tbyte),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o),
        .mem_req_o   (mem_req_o),
        .mem_ready_i (mem_ready_i),
        .mem_addr_o  (mem_addr_o),
        .mem_we_o    (mem_we_o),
        .mem_word_o  (mem_word_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i),
        .rf_addr_o   (rf_addr_o),
        .rf_we_o     (rf_we_o),
        .rf_wdata_o  (rf_wdata_o),
        .rf_rdata_i  (rf_rdata_i)
    );

    lss_span_check #(.RN(RN), .CW(CW)) u_span (
        .first_i (chk_first),
        .ra_i    (chk_ra),
        .rb_i    (chk_rb),
        .cnt_i   (chk_cnt),
        .hit_o   (span_hit)
    );

    lss_lane #(.DW(DW)) u_lane (
        .lane_i   (lane),
        .acc_i    (acc),
        .word_i   (rf_rdata_i),
        .byte_i   (mem_rdata_i[7:0]),
        .packed_o (packed_w),
        .byte_o   (tbyte)
    );

endmodule

// File: tb/lss_string_seq_bench.sv
module lss_string_seq_bench;

    localparam int PERIOD = 10;
    localparam int NV     = 14;

    typedef struct packed {
        logic        st;
        logic        ix;
        logic [31:0] base;
        logic [6:0]  cnt;
        logic [4:0]  first;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic        err;
        logic [3:0]  tg;
    } vec_t;

    // store, indexed, base, count, first, opA, opB, expected error, requirement
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b0, 32'h0000_0010, 7'd8,  5'd3,  5'd0, 5'd0, 1'b0, 4'd2},  // R2 words
        '{1'b0, 1'b0, 32'h0000_0021, 7'd11, 5'd31, 5'd0, 5'd0, 1'b0, 4'd3},  // R3 wrap + tail
        '{1'b0, 1'b0, 32'h0000_0040, 7'd2,  5'd5,  5'd0, 5'd0, 1'b0, 4'd3},  // R3 tail only
        '{1'b1, 1'b0, 32'h0000_0080, 7'd9,  5'd10, 5'd0, 5'd0, 1'b0, 4'd4},  // R4
        '{1'b1, 1'b0, 32'h0000_0090, 7'd3,  5'd31, 5'd0, 5'd0, 1'b0, 4'd4},  // R4 tail only
        '{1'b0, 1'b1, 32'h0000_0030, 7'd10, 5'd4,  5'd6, 5'd1, 1'b1, 4'd7},  // R7 A hit
        '{1'b0, 1'b1, 32'h0000_0030, 7'd10, 5'd4,  5'd0, 5'd7, 1'b0, 4'd7},  // R7 clear
        '{1'b0, 1'b1, 32'h0000_0030, 7'd12, 5'd30, 5'd0, 5'd0, 1'b1, 4'd7},  // R7 B hit after wrap
        '{1'b0, 1'b1, 32'h0000_0030, 7'd0,  5'd0,  5'd0, 5'd0, 1'b0, 4'd6},  // R6 indexed zero
        '{1'b0, 1'b1, 32'h0000_0030, 7'd5,  5'd0,  5'd0, 5'd3, 1'b0, 4'd8},  // R8 A exempt
        '{1'b0, 1'b0, 32'hFFFF_FFFE, 7'd6,  5'd8,  5'd0, 5'd0, 1'b0, 4'd5},  // R5 load wrap
        '{1'b1, 1'b1, 32'h0000_00C8, 7'd4,  5'd2,  5'd3, 5'd1, 1'b0, 4'd7},  // R7 store clear
        '{1'b0, 1'b0, 32'h0000_0050, 7'd0,  5'd9,  5'd0, 5'd0, 1'b0, 4'd6},  // R6 plain zero
        '{1'b1, 1'b0, 32'hFFFF_FFFD, 7'd5,  5'd12, 5'd0, 5'd0, 1'b0, 4'd5}   // R5 store wrap
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        store = 1'b0;
    logic        indexed = 1'b0;
    logic [31:0] base = '0;
    logic [6:0]  cnt = '0;
    logic [4:0]  first = '0;
    logic [4:0]  opa = '0;
    logic [4:0]  opb = '0;
    logic        busy, done, err;
    logic        mem_req, mem_ready, mem_we, mem_word;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [4:0]  rf_addr;
    logic        rf_we;
    logic [31:0] rf_wdata, rf_rdata;

    logic        stall_en = 1'b0;
    logic        phase = 1'b0;

    logic [7:0]  mem [256];
    logic [31:0] rf [32];
    logic [7:0]  em [256];
    logic [31:0] erf [32];

    int n_checks = 0;
    int n_fail = 0;
    int hs_cnt = 0;
    int rfw_cnt = 0;
    int hold_bad = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    logic        pend_we = 1'b0;
    logic        pend_word = 1'b0;

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) phase <= ~phase;
    assign mem_ready = !stall_en || phase;

    always_comb begin
        if (mem_word) begin
            mem_rdata = {mem[mem_addr[7:0]], mem[8'(mem_addr[7:0] + 8'd1)],
                         mem[8'(mem_addr[7:0] + 8'd2)], mem[8'(mem_addr[7:0] + 8'd3)]};
        end else begin
            mem_rdata = {24'h0, mem[mem_addr[7:0]]};
        end
    end
    assign rf_rdata = rf[rf_addr];

    lss_string_seq u_lss_string_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .store_i     (store),
        .indexed_i   (indexed),
        .base_addr_i (base),
        .byte_cnt_i  (cnt),
        .first_reg_i (first),
        .op_a_i      (opa),
        .op_b_i      (opb),
        .busy_o      (busy),
        .done_o      (done),
        .err_o       (err),
        .mem_req_o   (mem_req),
        .mem_ready_i (mem_ready),
        .mem_addr_o  (mem_addr),
        .mem_we_o    (mem_we),
        .mem_word_o  (mem_word),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata),
        .rf_addr_o   (rf_addr),
        .rf_we_o     (rf_we),
        .rf_wdata_o  (rf_wdata),
        .rf_rdata_i  (rf_rdata)
    );

    function automatic string tagname(input logic [3:0] t);
        case (t)
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // one cycle; memory and register effects are applied for the coming edge
    task automatic tick();
        @(negedge clk);
        if (pend && (!mem_req || mem_addr != pend_addr || mem_we != pend_we || mem_word != pend_word)) begin
            hold_bad++;
        end
        pend      = mem_req && !mem_ready;
        pend_addr = mem_addr;
        pend_we   = mem_we;
        pend_word = mem_word;
        if (mem_req && mem_ready) begin
            hs_cnt++;
            if (mem_we) begin
                if (mem_word) begin
                    for (int k = 0; k < 4; k++) begin
                        mem[8'(mem_addr[7:0] + 8'(k))] = mem_wdata[31-8*k -: 8];
                    end
                end else begin
                    mem[mem_addr[7:0]] = mem_wdata[7:0];
                end
            end
        end
        if (rf_we) begin
            rf[rf_addr] = rf_wdata;
            rfw_cnt++;
        end
    endtask

    task automatic fill(input int v);
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 13 + v * 5 + 1);
        for (int i = 0; i < 32; i++) rf[i] = {8'(i), 8'(v), 8'hA5, 8'(~i)};
    endtask

    // expected state from the requirements
    task automatic model(input vec_t v);
        logic [31:0] a;
        logic [4:0]  r;
        int          n;
        int          sh;
        logic [31:0] val;
        em  = mem;
        erf = rf;
        if (v.err || v.cnt == 0) return;
        a = v.base;
        r = v.first;
        n = int'(v.cnt);
        while (n >= 4) begin
            for (int k = 0; k < 4; k++) begin
                if (v.st) em[8'(a[7:0] + 8'(k))] = erf[r][31-8*k -: 8];
            end
            if (!v.st) erf[r] = {em[a[7:0]], em[8'(a[7:0] + 8'd1)], em[8'(a[7:0] + 8'd2)], em[8'(a[7:0] + 8'd3)]};
            r = r + 5'd1;
            a = a + 32'd4;
            n = n - 4;
        end
        sh  = 24;
        val = '0;
        while (n > 0) begin
            if (v.st) em[a[7:0]] = erf[r][sh +: 8];
            else val = val | (32'(em[a[7:0]]) << sh);
            a = a + 32'd1;
            sh = sh - 8;
            n = n - 1;
        end
        if (!v.st && (v.cnt % 4) != 0) erf[r] = val;
    endtask

    task automatic launch(input vec_t v);
        store   = v.st;
        indexed = v.ix;
        base    = v.base;
        cnt     = v.cnt;
        first   = v.first;
        opa     = v.ra;
        opb     = v.rb;
        start   = 1'b1;
        tick();
        start   = 1'b0;
    endtask

    task automatic wait_done(output logic e, input string tag);
        int guard;
        guard = 0;
        while (!done && guard < 3000) begin
            tick();
            guard++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL %s watchdog: actual no done expected done", tag);
        end
        e = err;
    endtask

    task automatic compare_state(input string tag);
        int bad_r;
        int bad_m;
        int fr;
        int fm;
        bad_r = 0;
        bad_m = 0;
        fr = 0;
        fm = 0;
        for (int i = 31; i >= 0; i--) if (rf[i] !== erf[i]) begin bad_r++; fr = i; end
        for (int i = 255; i >= 0; i--) if (mem[i] !== em[i]) begin bad_m++; fm = i; end
        check(bad_r == 0, tag, $sformatf("register %0d", fr), 64'(rf[fr]), 64'(erf[fr]));
        check(bad_m == 0, tag, $sformatf("memory byte %0d", fm), 64'(mem[fm]), 64'(em[fm]));
    endtask

    initial begin
        #(PERIOD * 190000);
        $display("FAIL global watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail + 1);
        $finish;
    end

    initial begin
        logic e;
        vec_t d1;
        vec_t d2;
        fill(0);
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        // reset state
        check(!busy && !done && !err, "R1", "idle flags after reset", {61'h0, busy, done, err}, 64'h0);
        check(!mem_req && !rf_we, "R11", "no request or write after reset", {62'h0, mem_req, rf_we}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            int exp_hs;
            fill(i);
            stall_en = i[0];
            model(VT[i]);
            hs_cnt = 0;
            rfw_cnt = 0;
            hold_bad = 0;
            exp_hs = (VT[i].err) ? 0 : int'(VT[i].cnt) / 4 + int'(VT[i].cnt) % 4;
            launch(VT[i]);
            wait_done(e, tagname(VT[i].tg));
            check(e == VT[i].err, "R7", $sformatf("error flag vector %0d", i), 64'(e), 64'(VT[i].err));
            tick();
            check(!done && !busy, "R9", $sformatf("single done pulse vector %0d", i), {62'h0, done, busy}, 64'h0);
            check(hs_cnt == exp_hs, tagname(VT[i].tg), $sformatf("request count vector %0d", i), 64'(hs_cnt), 64'(exp_hs));
            check(rfw_cnt == (VT[i].st ? 0 : exp_hs), "R11", $sformatf("register writes vector %0d", i),
                  64'(rfw_cnt), 64'(VT[i].st ? 0 : exp_hs));
            check(hold_bad == 0, "R10", $sformatf("request held while stalled vector %0d", i), 64'(hold_bad), 64'h0);
            compare_state(tagname(VT[i].tg));
        end

        // start while busy is ignored
        fill(20);
        stall_en = 1'b1;
        d1 = '{1'b1, 1'b0, 32'h0000_00A0, 7'd16, 5'd20, 5'd0, 5'd0, 1'b0, 4'd2};
        d2 = '{1'b0, 1'b0, 32'h0000_0000, 7'd4,  5'd0,  5'd0, 5'd0, 1'b0, 4'd2};
        model(d1);
        hs_cnt = 0;
        rfw_cnt = 0;
        launch(d1);
        check(busy, "R1", "busy after accepted start", 64'(busy), 64'h1);
        tick();
        launch(d2);
        wait_done(e, "R1");
        tick();
        repeat (5) tick();
        check(hs_cnt == 4, "R1", "requests with start during busy", 64'(hs_cnt), 64'd4);
        check(rfw_cnt == 0, "R1", "no load from ignored start", 64'(rfw_cnt), 64'd0);
        check(!busy, "R1", "idle after ignored start", 64'(busy), 64'h0);
        compare_state("R1");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule